// File: doc/BRIEF.md
# Serial LED Sink Register with Fault Capture

This block is the digital core of a multi-channel constant-current LED sink. Display data arrives one bit per rising edge of a serial clock and moves through a shift register. The far end of that register drives the serial output, so several parts can be cascaded. A storage latch controlled by a latch-enable input copies the register into the channel drivers. An active-low output enable gates every channel, so a host can dim the LEDs by pulse-width modulating that pin.

Fault checking reuses the two control pins. A fixed five-step pattern on output enable and latch enable, sampled at serial clock edges, switches the block into a detection mode, and a second pattern switches it back. In detection mode the host latches all ones so that every channel is driven, then pulls output enable low for a test window. When output enable returns high, each channel's comparator flags are folded into one fault bit, and those bits are loaded into the shift register. The host reads them out through the same serial format it uses for display data. Everything runs on one system clock. The serial clock, the serial input and the control pins are assumed to be synchronous to it.

Top module: `led_sink_core`

## Requirements
- R1: A synchronous active-low reset clears the shift register and the storage latch. `chan_on` and `ser_out` read 0 and the block starts in normal (non-detection) mode.
- R2: A rising edge of `ser_clk`, seen on one system clock, moves `ser_in` into stage 0 and each stage k into stage k+1. `ser_out` always equals the top stage, so the first bit shifted in appears first. Without a `ser_clk` rising edge the register does not change.
- R3: While `latch_en` is 1 the storage latch follows the shift register. While `latch_en` is 0 it keeps its value even as new data is shifted in.
- R4: While `out_en_n` is 1 every bit of `chan_on` is 0. While `out_en_n` is 0, bit i of `chan_on` equals latch bit i, in both normal and detection mode.
- R5: In normal mode, five consecutive `ser_clk` rising edges that sample (`out_en_n`,`latch_en`) as (1,0), (0,0), (1,0), (1,1), (1,0) switch the block into detection mode.
- R6: In detection mode, five consecutive `ser_clk` rising edges sampling (1,0), (0,0), (1,0), (1,0), (1,0) return the block to normal mode. The entry pattern has no effect in detection mode, and the return pattern has no effect in normal mode.
- R7: In detection mode, if `out_en_n` has been 0 for at least MIN_WIN system-clock edges, the first clock edge that sees it at 1 again loads the shift register. The loaded value has bit i = `low_cur_flag[i]` OR `high_vout_flag[i]` (1 = fault). Serial shifts then present bit N_CH-1 first on `ser_out`. A window of exactly MIN_WIN edges captures.
- R8: In detection mode, a low pulse on `out_en_n` shorter than MIN_WIN system-clock edges captures nothing, and the shift register keeps its contents.
- R9: In normal mode, an `out_en_n` low pulse of any length never loads the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock; its rising edges are detected on `clk` |
| ser_in | input | 1 | Serial data input |
| latch_en | input | 1 | Storage latch enable, transparent when 1 |
| out_en_n | input | 1 | Channel enable, active low; test window in detection mode |
| low_cur_flag | input | N_CH | Per-channel flag: current at or below half of the set current |
| high_vout_flag | input | N_CH | Per-channel flag: output voltage at or above the short threshold |
| ser_out | output | 1 | Serial data output, top stage of the shift register |
| chan_on | output | N_CH | Per-channel drive enable |

## Verification
The bench builds the block with N_CH = 8 and MIN_WIN = 16, which replaces the default window of one microsecond at 250 MHz. The short window makes it cheap to place a test pulse exactly one edge short of the limit and exactly at it, so both sides of the capture boundary are checked. With eight channels, fault patterns that are asymmetric in bit order (0x49, 0x81) confirm that channel N_CH-1 leaves the register first. The bench walks the mode patterns in both directions and applies each pattern in the mode where it must be ignored.

// File: rtl/lsk_pkg.sv
// Package: shared constants and types for the LED sink core.
// Control pairs are packed as {out_en_n, latch_en}; the oldest pair of a
// mode pattern sits in the most significant bits.
package lsk_pkg;

    localparam int SEQ_LEN = 5;
    localparam int SEQ_W   = 2 * SEQ_LEN;

    // Pattern that switches normal -> detection
    localparam logic [SEQ_W-1:0] ENTER_PAT  = 10'b10_00_10_11_10;
    // Pattern that switches detection -> normal
    localparam logic [SEQ_W-1:0] RESUME_PAT = 10'b10_00_10_10_10;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_DETECT = 1'b1
    } lsk_mode_e;

endpackage

// File: rtl/lsk_edge_sense.sv
// Module: lsk_edge_sense
// Detects the rising edges of the serial clock and of the output-enable pin
// on the system clock.
// Assumes both inputs are already synchronous to clk.
module lsk_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic out_en_n,
    output logic ser_rise,
    output logic oe_rise
);

    logic ser_clk_q;
    logic oe_n_q;

    // Purpose: keep last-cycle copies of the watched pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_clk_q <= 1'b0;
            oe_n_q    <= 1'b1;
        end else begin
            ser_clk_q <= ser_clk;
            oe_n_q    <= out_en_n;
        end
    end

    // Purpose: flag a 0 -> 1 transition on each watched pin
    always_comb begin
        ser_rise = ser_clk & ~ser_clk_q;
        oe_rise  = out_en_n & ~oe_n_q;
    end

    AST_SINGLE_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ser_rise |=> !ser_rise);  // R2

endmodule

// File: rtl/lsk_shift_reg.sv
// Module: lsk_shift_reg
// N-stage serial-in, parallel-out register with a parallel load port.
// A parallel load takes priority over a shift in the same cycle.
// Assumes step is a one-cycle strobe.
module lsk_shift_reg #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            sdi,
    input  logic            load,
    input  logic [N_CH-1:0] load_val,
    output logic [N_CH-1:0] q,
    output logic            sdo
);

    localparam int TOP = N_CH - 1;

    logic [N_CH-1:0] stages_q;

    // Purpose: load captured results, or advance one stage per serial edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages_q <= '0;
        end else if (load) begin
            stages_q <= load_val;
        end else if (step) begin
            stages_q <= {stages_q[TOP-1:0], sdi};
        end
    end

    assign q   = stages_q;
    assign sdo = stages_q[TOP];

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (q[0] == $past(sdi)));  // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(q));  // R2
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(load_val)));  // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (q == '0));  // R1

endmodule

// File: rtl/lsk_store_latch.sv
// Module: lsk_store_latch
// Level-sensitive storage built from a hold register: the output follows d
// while le is 1 and the hold register keeps the last value seen.
// Assumes le is synchronous to clk.
module lsk_store_latch #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            le,
    input  logic [N_CH-1:0] d,
    output logic [N_CH-1:0] q
);

    logic [N_CH-1:0] hold_q;

    // Purpose: choose transparent data or the held copy, channel by channel
    for (genvar i = 0; i < N_CH; i++) begin : g_bit
        assign q[i] = le ? d[i] : hold_q[i];
    end

    // Purpose: remember the latch output for the hold phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= q;
        end
    end

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && $past(!le)) |-> $stable(q));  // R3

endmodule

// File: rtl/lsk_mode_ctrl.sv
// Module: lsk_mode_ctrl
// Samples {out_en_n, latch_en} at every serial edge and compares the last
// SEQ_LEN samples with the enter and resume patterns. The history is
// cleared after a match, so each switch needs a fresh full pattern.
// Assumes step is a one-cycle strobe.
module lsk_mode_ctrl
    import lsk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic out_en_n,
    input  logic latch_en,
    output logic detect
);

    logic [SEQ_W-1:0] hist_q;
    logic [SEQ_W-1:0] hist_nx;
    lsk_mode_e        mode_q;

    // Purpose: history including the pair sampled now
    always_comb begin
        hist_nx = {hist_q[SEQ_W-3:0], out_en_n, latch_en};
    end

    // Purpose: record control pairs and switch mode on a full pattern
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            mode_q <= MODE_NORMAL;
        end else if (step) begin
            if (mode_q == MODE_NORMAL && hist_nx == ENTER_PAT) begin
                mode_q <= MODE_DETECT;
                hist_q <= '0;
            end else if (mode_q == MODE_DETECT && hist_nx == RESUME_PAT) begin
                mode_q <= MODE_NORMAL;
                hist_q <= '0;
            end else begin
                hist_q <= hist_nx;
            end
        end
    end

    assign detect = (mode_q == MODE_DETECT);

    AST_MODE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (detect != $past(detect)) |-> $past(step));  // R5
    AST_ENTER_NEEDS_LE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(detect) |-> ($past(!out_en_n) == 1'b0));  // R5

endmodule

// File: rtl/lsk_fault_window.sv
// Module: lsk_fault_window
// Times the output-enable low window in detection mode and, when the pin
// returns high after at least MIN_WIN cycles, asks for the fault vector to
// be loaded. The counter saturates at MIN_WIN.
// Assumes the comparator flags are stable at the end of the window.
module lsk_fault_window #(
    parameter int N_CH    = 8,
    parameter int MIN_WIN = 250
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            detect,
    input  logic            out_en_n,
    input  logic            oe_rise,
    input  logic [N_CH-1:0] low_cur_flag,
    input  logic [N_CH-1:0] high_vout_flag,
    output logic            capture,
    output logic [N_CH-1:0] fault_vec
);

    localparam int CW = $clog2(MIN_WIN + 1);
    localparam logic [CW-1:0] WIN_LIM = CW'(MIN_WIN);

    logic [CW-1:0] win_cnt_q;

    // Purpose: count low cycles of the enable pin while testing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt_q <= '0;
        end else if (!detect || out_en_n) begin
            win_cnt_q <= '0;
        end else if (win_cnt_q < WIN_LIM) begin
            win_cnt_q <= win_cnt_q + 1'b1;
        end
    end

    // Purpose: fold the two comparator flags of each channel into one bit
    for (genvar i = 0; i < N_CH; i++) begin : g_fault
        assign fault_vec[i] = low_cur_flag[i] | high_vout_flag[i];
    end

    // Purpose: a capture needs detection mode, a rising edge and a full window
    always_comb begin
        capture = detect && oe_rise && (win_cnt_q >= WIN_LIM);
    end

    AST_CAPTURE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> $past(!out_en_n));  // R7
    AST_CAPTURE_IN_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> detect);  // R9

endmodule

// File: rtl/led_sink_core.sv
// Module: led_sink_core
// Top of the LED sink digital core: serial shift register, storage latch,
// output gating, detection-mode control and fault capture.
// Assumes ser_clk, ser_in, latch_en, out_en_n and the flags are synchronous
// to clk, and that ser_clk stays high and low for at least one clk each.
module led_sink_core #(
    parameter int N_CH    = 8,
    parameter int MIN_WIN = 250
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_clk,
    input  logic            ser_in,
    input  logic            latch_en,
    input  logic            out_en_n,
    input  logic [N_CH-1:0] low_cur_flag,
    input  logic [N_CH-1:0] high_vout_flag,
    output logic            ser_out,
    output logic [N_CH-1:0] chan_on
);

    logic            ser_rise;
    logic            oe_rise;
    logic            detect;
    logic            capture;
    logic [N_CH-1:0] fault_vec;
    logic [N_CH-1:0] shreg;
    logic [N_CH-1:0] latched;

    lsk_edge_sense u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .out_en_n (out_en_n),
        .ser_rise (ser_rise),
        .oe_rise  (oe_rise)
    );

    lsk_mode_ctrl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (ser_rise),
        .out_en_n (out_en_n),
        .latch_en (latch_en),
        .detect   (detect)
    );

    lsk_fault_window #(.N_CH(N_CH), .MIN_WIN(MIN_WIN)) u_win (
        .clk            (clk),
        .rst_n          (rst_n),
        .detect         (detect),
        .out_en_n       (out_en_n),
        .oe_rise        (oe_rise),
        .low_cur_flag   (low_cur_flag),
        .high_vout_flag (high_vout_flag),
        .capture        (capture),
        .fault_vec      (fault_vec)
    );

    lsk_shift_reg #(.N_CH(N_CH)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (ser_rise),
        .sdi      (ser_in),
        .load     (capture),
        .load_val (fault_vec),
        .q        (shreg),
        .sdo      (ser_out)
    );

    lsk_store_latch #(.N_CH(N_CH)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (latch_en),
        .d     (shreg),
        .q     (latched)
    );

    // Purpose: gate every channel with the active-low enable
    always_comb begin
        chan_on = out_en_n ? '0 : latched;
    end

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (chan_on == '0));  // R4
    AST_RESET_SEROUT: assert property (@(posedge clk)
        !rst_n |=> (ser_out == 1'b0));  // R1

endmodule

// File: tb/tb_led_sink_core.sv
`timescale 1ns/1ps
module tb_led_sink_core;

    localparam int N = 8;
    localparam int WIN = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_in = 1'b0;
    logic latch_en = 1'b0;
    logic out_en_n = 1'b1;
    logic [N-1:0] low_cur_flag = '0;
    logic [N-1:0] high_vout_flag = '0;
    logic ser_out;
    logic [N-1:0] chan_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // scoreboard queues: kind 0 = ser_out bit, kind 1 = chan_on vector
    int        q_kind[$];
    logic [7:0] q_exp[$];
    string     q_req[$];
    time       q_t[$];

    always #2 clk = ~clk;

    led_sink_core #(.N_CH(N), .MIN_WIN(WIN)) dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_in(ser_in),
        .latch_en(latch_en), .out_en_n(out_en_n),
        .low_cur_flag(low_cur_flag), .high_vout_flag(high_vout_flag),
        .ser_out(ser_out), .chan_on(chan_on)
    );

    // monitor: pops one expected item per falling edge, after a rising edge
    always begin
        @(negedge clk);
        if (q_kind.size() > 0 && q_t[0] < $time) begin
            int k;
            logic [7:0] e;
            logic [7:0] a;
            string r;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            r = q_req.pop_front();
            void'(q_t.pop_front());
            a = (k == 0) ? {7'b0, ser_out} : chan_on;
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", r, a, e);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input int kind, input logic [7:0] e, input string r);
        q_kind.push_back(kind);
        q_exp.push_back(e);
        q_req.push_back(r);
        q_t.push_back($time);
        wait (q_kind.size() == 0);
    endtask

    task automatic pulse(input logic d, input logic oe, input logic le);
        ser_in = d; out_en_n = oe; latch_en = le;
        ser_clk = 1'b1;
        tick(2);
        ser_clk = 1'b0;
        tick(2);
    endtask

    task automatic shift_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) pulse(v[i], 1'b1, 1'b0);
    endtask

    task automatic read_byte(input logic [7:0] e, input string r);
        for (int i = 7; i >= 0; i--) begin
            expect_item(0, {7'b0, e[i]}, r);
            pulse(1'b0, 1'b1, 1'b0);
        end
    endtask

    task automatic enter_seq();
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b0, 1'b0);
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b1, 1'b1);
        pulse(1'b0, 1'b1, 1'b0);
    endtask

    task automatic resume_seq();
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b0, 1'b0);
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b1, 1'b0);
    endtask

    // low window of n clock edges, then enable back high
    task automatic window(input int n);
        out_en_n = 1'b0;
        tick(n);
        out_en_n = 1'b1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        out_en_n = 1'b0; latch_en = 1'b1;
        expect_item(1, 8'h00, "R1 chan_on after reset");
        expect_item(0, 8'h00, "R1 ser_out after reset");
        latch_en = 1'b0; out_en_n = 1'b1;

        // R2: first bit in comes out first
        shift_byte(8'hA5);
        expect_item(0, 8'h01, "R2 ser_out top stage");
        tick(10);
        expect_item(0, 8'h01, "R2 no edge no shift");
        // R3/R4: latch transparent, outputs follow
        latch_en = 1'b1; out_en_n = 1'b0;
        expect_item(1, 8'hA5, "R3 transparent latch");
        latch_en = 1'b0;
        for (int i = 7; i >= 0; i--) pulse(logic'(8'h3C >> i), 1'b0, 1'b0);
        expect_item(1, 8'hA5, "R3 latch holds while shifting");
        out_en_n = 1'b1;
        expect_item(1, 8'h00, "R4 all off when disabled");
        out_en_n = 1'b0;
        expect_item(1, 8'hA5, "R4 on follows latch");
        latch_en = 1'b1;
        expect_item(1, 8'h3C, "R3 latch reopens");
        latch_en = 1'b0;

        // R9: long enable pulse in normal mode loads nothing
        low_cur_flag = 8'hFF;
        out_en_n = 1'b1; tick(2);
        window(30); tick(2);
        latch_en = 1'b1; out_en_n = 1'b0;
        expect_item(1, 8'h3C, "R9 no capture in normal mode");
        latch_en = 1'b0; out_en_n = 1'b1;

        // R5/R7: enter detection, drive all, capture faults
        enter_seq();
        shift_byte(8'hFF);
        latch_en = 1'b1; tick(1); latch_en = 1'b0;
        low_cur_flag = 8'h41; high_vout_flag = 8'h08;
        out_en_n = 1'b0;
        expect_item(1, 8'hFF, "R4 all channels driven in test");
        tick(20);
        out_en_n = 1'b1;
        read_byte(8'h49, "R5 R7 fault readout");

        // R8: one edge short of the window
        shift_byte(8'h96);
        low_cur_flag = 8'h00; high_vout_flag = 8'hFF;
        window(WIN - 1);
        read_byte(8'h96, "R8 short window ignored");
        // R7: exactly the window
        shift_byte(8'h5A);
        window(WIN);
        read_byte(8'hFF, "R7 window boundary capture");

        // R6: entry pattern in detection mode is ignored
        enter_seq();
        shift_byte(8'hFF);
        latch_en = 1'b1; tick(1); latch_en = 1'b0;
        low_cur_flag = 8'h81; high_vout_flag = 8'h00;
        window(20);
        read_byte(8'h81, "R6 entry ignored in detection");

        // R6: resume returns to normal
        resume_seq();
        shift_byte(8'hC3);
        window(20);
        read_byte(8'hC3, "R6 resumed to normal");

        // R6: resume in normal mode is ignored
        resume_seq();
        shift_byte(8'h33);
        window(20);
        read_byte(8'h33, "R6 resume ignored in normal");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule